// File: doc/BRIEF.md
# ADC conversion timing controller

This block times a single analog-to-digital conversion for an external successive-approximation datapath. Software picks a conversion clock through a 3-bit select code: six codes divide the system clock by a power of two from 2 to 64, and any code whose two low bits are both 1 picks a free-running internal RC oscillator instead. The RC oscillator's tick enters the block asynchronously.

A start request launches a conversion of eleven conversion-clock periods. The first period covers acquisition and setup. Each of the ten periods after it produces one bit step, with the bit index counting down from the MSB. At the end of the eleventh period the block emits a done pulse and sets a sticky completion flag. The flag is set whether or not the interrupt is enabled, and only software clears it. The flag, gated by an enable, drives either a high-priority or a low-priority interrupt line. While the device sleeps it also drives a wake request.

In sleep the divided system-clock sources stop, so a conversion on one of them freezes until the device wakes. A conversion on the RC source keeps running in sleep.

Top module: `adc_conv_timer`

## Requirements
- R1: Select codes give these period lengths in system-clock cycles: 000 gives 2, 100 gives 4, 001 gives 8, 101 gives 16, 010 gives 32 and 110 gives 64. `conv_clk_en` pulses for one cycle at the end of each period. With the start accepted at clock edge E, the k-th pulse is visible after edge E + k·div.
- R2: Codes 011 and 111 select the RC tick. Each rising edge of `rc_tick` ends one period after a constant synchronisation delay, so consecutive `conv_clk_en` pulses are as far apart as consecutive tick rising edges.
- R3: A conversion is exactly 11 periods. `done` is a one-cycle pulse that appears together with the 11th `conv_clk_en` pulse. `busy` rises after the accepting edge and falls in the same cycle that `done` appears.
- R4: `bit_strobe` pulses together with `conv_clk_en` for periods 2 to 11 only, 10 pulses in all. During those pulses `bit_idx` reads 9, 8, …, 0 in that order.
- R5: A `start` that arrives while `busy` is high has no effect on the running conversion's timing.
- R6: A change of `clk_sel` while `busy` is high has no effect until the next accepted start.
- R7: `flag` goes to 1 in the same cycle as `done`, whatever `int_en` is. It then stays at 1 until a cycle with `flag_clr` high. When completion and `flag_clr` coincide, the flag is set.
- R8: One cycle after the inputs settle, `irq_hi` equals `flag & int_en & int_pri` and `irq_lo` equals `flag & int_en & ~int_pri`.
- R9: One cycle after the inputs settle, `wake` equals `flag & int_en & sleep`.
- R10: While `sleep` is high, a conversion on a divided source produces no periods and stays busy, then resumes on wake with all 11 periods. A conversion on the RC source completes during sleep.
- R11: After reset all outputs are 0, and a `start` held during reset starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Conversion clock select code |
| start | input | 1 | Conversion start request |
| sleep | input | 1 | Device sleep indication |
| rc_tick | input | 1 | Asynchronous RC oscillator tick |
| flag_clr | input | 1 | Software clear of the completion flag |
| int_en | input | 1 | Completion interrupt enable |
| int_pri | input | 1 | Priority select, 1 = high |
| conv_clk_en | output | 1 | One pulse per conversion-clock period |
| bit_strobe | output | 1 | Bit-step strobe for periods 2 to 11 |
| bit_idx | output | 4 | Result bit index of the current strobe |
| done | output | 1 | Conversion complete pulse |
| busy | output | 1 | Conversion in progress |
| flag | output | 1 | Sticky completion flag |
| irq_hi | output | 1 | High-priority interrupt request |
| irq_lo | output | 1 | Low-priority interrupt request |
| wake | output | 1 | Wake request during sleep |

## Verification
The bench builds the block with its defaults: RES_BITS of 10, MAX_SHIFT of 6 and SYNC_STAGES of 2. With these values every select code is reachable, including the divide-by-64 setting, whose conversion lasts 704 cycles. Each period is checked cycle by cycle under each code, while random starts and select changes land mid-conversion. The two-stage synchroniser gives a fixed tick latency, so the spacing of RC-driven pulses can be compared exactly against the tick period, both awake and asleep.

// File: rtl/adc_tim_pkg.sv
package adc_tim_pkg;

  localparam int SHIFT_W = 3;

  typedef struct packed {
    logic               use_rc;
    logic [SHIFT_W-1:0] shift;
  } clksel_t;

  // Period length is 2**shift system cycles; shift = {code[1:0],code[2]} + 1.
  function automatic clksel_t decode_sel(input logic [2:0] code);
    clksel_t r;
    r.use_rc = (code[1:0] == 2'b11);
    r.shift  = r.use_rc ? '0 : ({code[1:0], code[2]} + 3'd1);
    return r;
  endfunction

endpackage

// File: rtl/adc_tick_sync.sv
module adc_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_async,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], tick_async};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/adc_period_gen.sv
module adc_period_gen
  import adc_tim_pkg::*;
#(
  parameter int MAX_SHIFT = 6
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    restart,
  input  logic    run,
  input  logic    hold,
  input  clksel_t sel,
  input  logic    rc_rise,
  output logic    per_stb
);
  localparam int CW = MAX_SHIFT + 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          div_hit;
  logic          div_run;

  assign lim     = (ONE << sel.shift) - ONE;
  assign div_hit = (cnt == lim);
  assign div_run = run & ~sel.use_rc & ~hold;
  assign per_stb = run & (sel.use_rc ? rc_rise : (div_hit & ~hold));

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (div_run)   cnt <= div_hit ? '0 : cnt + ONE;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (run && !sel.use_rc) |-> (cnt <= lim)); // R1
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int RES_BITS = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        accept,
  input  logic                        per_stb,
  output logic                        busy,
  output logic                        conv_pulse,
  output logic                        bit_stb,
  output logic [$clog2(RES_BITS)-1:0] bit_idx,
  output logic                        done_pulse,
  output logic                        finishing
);
  localparam int N_PER = RES_BITS + 1;
  localparam int PW    = $clog2(N_PER + 1);
  localparam int IW    = $clog2(RES_BITS);

  logic [PW-1:0] pcnt;
  logic          last_per;

  assign last_per  = (pcnt == PW'(N_PER - 1));
  assign finishing = busy & per_stb & last_per;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      pcnt       <= '0;
      conv_pulse <= 1'b0;
      bit_stb    <= 1'b0;
      bit_idx    <= '0;
      done_pulse <= 1'b0;
    end else begin
      conv_pulse <= 1'b0;
      bit_stb    <= 1'b0;
      done_pulse <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        pcnt <= '0;
      end else if (busy && per_stb) begin
        conv_pulse <= 1'b1;
        if (pcnt != '0) begin
          bit_stb <= 1'b1;
          bit_idx <= IW'(RES_BITS - 32'(pcnt));
        end
        if (last_per) begin
          done_pulse <= 1'b1;
          busy       <= 1'b0;
          pcnt       <= '0;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
    end
  end

  AST_PCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    pcnt < PW'(N_PER)); // R3
  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> !busy); // R3
  AST_STB_WITH_PERIOD: assert property (@(posedge clk) disable iff (rst)
    bit_stb |-> conv_pulse); // R4
endmodule

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic flag_clr,
  input  logic int_en,
  input  logic int_pri,
  input  logic sleep,
  output logic flag,
  output logic irq_hi,
  output logic irq_lo,
  output logic wake
);
  logic flag_n;
  logic req_n;

  assign flag_n = set_evt | (flag & ~flag_clr);
  assign req_n  = flag_n & int_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      irq_hi <= 1'b0;
      irq_lo <= 1'b0;
      wake   <= 1'b0;
    end else begin
      flag   <= flag_n;
      irq_hi <= req_n & int_pri;
      irq_lo <= req_n & ~int_pri;
      wake   <= req_n & sleep;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag); // R7
  AST_PRI_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_hi, irq_lo})); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (irq_hi || irq_lo) |-> flag); // R8
  AST_WAKE_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
    wake |-> ($past(sleep) && flag)); // R9
endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
  import adc_tim_pkg::*;
#(
  parameter int RES_BITS    = 10,
  parameter int MAX_SHIFT   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [2:0]                  clk_sel,
  input  logic                        start,
  input  logic                        sleep,
  input  logic                        rc_tick,
  input  logic                        flag_clr,
  input  logic                        int_en,
  input  logic                        int_pri,
  output logic                        conv_clk_en,
  output logic                        bit_strobe,
  output logic [$clog2(RES_BITS)-1:0] bit_idx,
  output logic                        done,
  output logic                        busy,
  output logic                        flag,
  output logic                        irq_hi,
  output logic                        irq_lo,
  output logic                        wake
);
  clksel_t sel_q;
  logic    accept;
  logic    rc_rise;
  logic    per_stb;
  logic    finishing;

  assign accept = start & ~busy;

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= decode_sel(3'b000);
    else if (accept) sel_q <= decode_sel(clk_sel);
  end

  adc_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .tick_async(rc_tick), .rise(rc_rise)
  );

  adc_period_gen #(.MAX_SHIFT(MAX_SHIFT)) u_per (
    .clk(clk), .rst(rst), .restart(accept), .run(busy), .hold(sleep),
    .sel(sel_q), .rc_rise(rc_rise), .per_stb(per_stb)
  );

  adc_conv_seq #(.RES_BITS(RES_BITS)) u_seq (
    .clk(clk), .rst(rst), .accept(accept), .per_stb(per_stb),
    .busy(busy), .conv_pulse(conv_clk_en), .bit_stb(bit_strobe),
    .bit_idx(bit_idx), .done_pulse(done), .finishing(finishing)
  );

  adc_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .set_evt(finishing), .flag_clr(flag_clr),
    .int_en(int_en), .int_pri(int_pri), .sleep(sleep),
    .flag(flag), .irq_hi(irq_hi), .irq_lo(irq_lo), .wake(wake)
  );

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(sel_q)); // R6
  AST_SLEEP_STOPS_DIV: assert property (@(posedge clk) disable iff (rst)
    (busy && sleep && !sel_q.use_rc) |=> !conv_clk_en); // R10
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    done |-> flag); // R7
endmodule

// File: tb/sim_adc_conv_timer.sv
module sim_adc_conv_timer;
  localparam int CLK_PERIOD = 10;
  localparam int RES       = 10;
  localparam int NPER      = RES + 1;
  localparam int RC_HALF   = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] clk_sel = 3'b000;
  logic       start = 1'b0, sleep = 1'b0, rc_tick = 1'b0;
  logic       flag_clr = 1'b0, int_en = 1'b0, int_pri = 1'b0;
  logic       conv_clk_en, bit_strobe, done, busy, flag, irq_hi, irq_lo, wake;
  logic [3:0] bit_idx;
  logic       rc_on = 1'b0;
  int         rc_phase = 0;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_conv_timer u0 (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .start(start), .sleep(sleep),
    .rc_tick(rc_tick), .flag_clr(flag_clr), .int_en(int_en), .int_pri(int_pri),
    .conv_clk_en(conv_clk_en), .bit_strobe(bit_strobe), .bit_idx(bit_idx),
    .done(done), .busy(busy), .flag(flag), .irq_hi(irq_hi), .irq_lo(irq_lo),
    .wake(wake)
  );

  always @(negedge clk) begin
    if (rc_on) begin
      if (rc_phase == RC_HALF - 1) begin
        rc_tick  <= ~rc_tick;
        rc_phase <= 0;
      end else begin
        rc_phase <= rc_phase + 1;
      end
    end
  end

  function automatic int exp_div(input logic [2:0] code);
    case (code)
      3'b000:  return 2;
      3'b100:  return 4;
      3'b001:  return 8;
      3'b101:  return 16;
      3'b010:  return 32;
      3'b110:  return 64;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Cycle-exact check of a divided-source conversion (R1, R3, R4, R5, R6, R7).
  task automatic conv_check(input logic [2:0] code, input bit rnd, input bit clr_hold);
    int d;
    int k;
    bit ep, eb;
    d = exp_div(code);
    clk_sel  = code;
    flag_clr = clr_hold;
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= NPER*d + 1; c++) begin
      if (c > 0) @(negedge clk);
      k  = c / d;
      ep = (c > 0) && (c % d == 0) && (c <= NPER*d);
      eb = ep && (k >= 2);
      check("R1", "conv_clk_en", int'(conv_clk_en), int'(ep));
      check("R4", "bit_strobe", int'(bit_strobe), int'(eb));
      if (eb) check("R4", "bit_idx", int'(bit_idx), RES + 1 - k);
      check("R3", "done", int'(done), int'(c == NPER*d));
      check("R3", "busy", int'(busy), int'(c < NPER*d));
      if (clr_hold && c < NPER*d) check("R7", "flag held clear", int'(flag), 0);
      if (c == NPER*d) check("R7", "flag at done", int'(flag), 1);
      if (rnd && c < NPER*d - 1) begin
        start   = ($urandom % 4) == 0;   // R5: starts while busy
        clk_sel = 3'($urandom);          // R6: select changes while busy
      end else begin
        start   = 1'b0;
        clk_sel = code;
      end
    end
    flag_clr = 1'b0;
  endtask

  // RC-source conversion: counts pulses and checks spacing (R2, R10).
  task automatic rc_conv(input logic [2:0] code, input bit slp);
    int pulses = 0, strobes = 0, last = -1, t = 0;
    bit seen_done = 1'b0;
    clk_sel = code;
    sleep   = slp;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!seen_done && t < 2000) begin
      @(negedge clk);
      t++;
      if (conv_clk_en) begin
        if (last >= 0) check("R2", "rc period spacing", t - last, 2*RC_HALF);
        last = t;
        pulses++;
      end
      if (bit_strobe) strobes++;
      if (done) seen_done = 1'b1;
    end
    check(slp ? "R10" : "R2", "rc done seen", int'(seen_done), 1);
    check("R2", "rc period count", pulses, NPER);
    check("R4", "rc strobe count", strobes, RES);
    sleep = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_sim();
  end

  initial begin
    void'($urandom(32'd2024));
    start = 1'b1;                       // R11: start during reset is dropped
    repeat (4) @(negedge clk);
    rst = 1'b0;
    start = 1'b0;
    @(negedge clk);
    check("R11", "busy after reset", int'(busy), 0);
    check("R11", "outputs after reset",
          int'({conv_clk_en, bit_strobe, done, flag, irq_hi, irq_lo, wake, bit_idx}), 0);

    // R1: every divided code, directed
    conv_check(3'b000, 1'b0, 1'b0);
    conv_check(3'b100, 1'b0, 1'b0);
    conv_check(3'b001, 1'b0, 1'b0);
    conv_check(3'b101, 1'b0, 1'b0);
    conv_check(3'b010, 1'b0, 1'b0);
    conv_check(3'b110, 1'b0, 1'b0);

    // R7: flag set without enable, irq stays low (R8)
    @(negedge clk);
    check("R7", "flag sticky no enable", int'(flag), 1);
    check("R8", "irq with enable off", int'(irq_hi | irq_lo), 0);
    int_en = 1'b1; int_pri = 1'b1;
    @(negedge clk);
    check("R8", "irq_hi", int'(irq_hi), 1);
    check("R8", "irq_lo", int'(irq_lo), 0);
    int_pri = 1'b0;
    @(negedge clk);
    check("R8", "irq_lo low pri", int'(irq_lo), 1);
    check("R8", "irq_hi low pri", int'(irq_hi), 0);
    check("R9", "wake awake", int'(wake), 0);
    sleep = 1'b1;
    @(negedge clk);
    check("R9", "wake asleep", int'(wake), 1);
    sleep = 1'b0;
    repeat (20) @(negedge clk);
    check("R7", "flag still set", int'(flag), 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R7", "flag cleared", int'(flag), 0);
    check("R8", "irq after clear", int'(irq_hi | irq_lo), 0);

    // R7: clear held across completion; set wins
    conv_check(3'b100, 1'b0, 1'b1);
    check("R7", "flag after held clear", int'(flag), 0);

    // R5, R6: random starts and select changes mid-run
    for (int i = 0; i < 12; i++) begin
      logic [2:0] code;
      code = 3'($urandom);
      if (code[1:0] == 2'b11) code[1:0] = 2'b00;
      conv_check(code, 1'b1, ($urandom % 3) == 0);
    end

    // R10: divided source frozen in sleep, resumes on wake
    begin
      int p = 0;
      bit seen = 1'b0;
      clk_sel = 3'b000; sleep = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (40) begin
        @(negedge clk);
        if (conv_clk_en) p++;
      end
      check("R10", "periods in sleep", p, 0);
      check("R10", "busy in sleep", int'(busy), 1);
      sleep = 1'b0;
      for (int t = 0; t < 200 && !seen; t++) begin
        @(negedge clk);
        if (conv_clk_en) p++;
        if (done) seen = 1'b1;
      end
      check("R10", "periods after wake", p, NPER);
      check("R10", "done after wake", int'(seen), 1);
    end

    // R2, R10: RC source awake and asleep
    rc_on = 1'b1;
    repeat (30) @(negedge clk);
    rc_conv(3'b011, 1'b0);
    rc_conv(3'b111, 1'b1);
    rc_on = 1'b0;

    repeat (5) @(negedge clk);
    finish_sim();
  end
endmodule